// File: doc/BRIEF.md
# Programmable Down-Counting Timer Channel

A single timer channel that counts down on a shared tick enable, normally a 1 MHz strobe made elsewhere. Software writes a load word that holds an enable flag, a repeat flag and a 29-bit count N. The channel then expires after N+1 ticks, so a count of 0 expires on the very next tick. Each expiry sets a level interrupt, which stays high until software clears it by writing a one to the clear bit of the status word.

In oneshot mode the channel turns itself off after it expires. In repeat mode it reloads N and expires again every N+1 ticks. Writing an all-zero load word stops the channel. The status word reads back the remaining count and the interrupt flag. Each channel decodes three address bits, which gives an 8-byte register block, so several instances can sit side by side at 8-byte spacing. Address bit 2 picks the word: 0 is the load word and 1 is the status word.

Top module: `tick_timer_chan`

## Requirements
- R1: After synchronous reset, irq is 0, bus_rdata is 0, the channel is disabled, and the load word and the remaining count read back as 0.
- R2: A write with bus_addr[2]=0 stores bit 31 as enable, bit 30 as repeat and bits 28:0 as count N. It restarts the remaining count at N in the same clock edge, and this load overrides any tick in that cycle.
- R3: The remaining count drops by one only on clock edges where tick_en is high and the channel is enabled. Otherwise it holds.
- R4: An enabled channel expires on the (N+1)-th tick after a load, so N=0 expires on the first tick. irq is high from the clock edge of the expiring tick onwards.
- R5: In oneshot mode (bit 30 = 0), expiry clears the enable bit, so bit 31 of the load word reads back 0. Counting stops with the remaining count at 0.
- R6: In repeat mode (bit 30 = 1), expiry reloads N, and the channel keeps expiring every N+1 ticks.
- R7: Writing an all-zero load word stops the channel. No further expiry happens, whatever tick_en does.
- R8: irq stays high until a write with bus_addr[2]=1 has bit 30 set. A status write with bit 30 clear has no effect on irq.
- R9: When a clear write and an expiry fall in the same cycle, irq stays high.
- R10: A read strobe loads bus_rdata at the next clock edge, and bus_rdata holds its value between strobes.
  - With bus_addr[2]=0, the read returns the load word: enable at bit 31, repeat at bit 30 and N at bits 28:0.
  - With bus_addr[2]=1, the read returns the remaining count at bits 28:0 and irq at bit 30. All other bits are 0.
  - bus_addr[1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe, one cycle per tick |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Byte offset inside the channel block; bit 2 selects the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, set on expiry, cleared by software |

## Verification
A write takes effect at the clock edge that samples it. An expiring tick raises irq at that same edge, and read data appears one edge after the strobe. Nothing in the block has more latency than one register. The bench drives all inputs on the falling edge. A behavioural model advances on each rising edge from the same inputs. irq and bus_rdata are compared with the model at the following falling edge, which is exactly one register stage after the stimulus. Directed sequences count ticks to the expiring one, and then probe the state through the read port before the next stimulus. These sequences cover loads of 0, restart in mid-count, repeat reload, a clear that collides with an expiry, and a stopped channel that keeps receiving ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int EN_BIT  = 31;
  localparam int PER_BIT = 30;
  localparam int CLR_BIT = 30;
  localparam int IRQ_BIT = 30;
  localparam int SEL_BIT = 2;

  typedef enum logic {
    SEL_LOAD = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 29,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              expire,
  output logic              load_wr,
  output logic              clr_wr,
  output logic              run_en,
  output logic              per_mode,
  output logic [CNT_W-1:0]  reload_val
);
  reg_sel_e sel;
  logic [ADDR_W-1:0] unused_addr;
  logic [DATA_W-1:0] unused_wdata;

  assign unused_addr  = bus_addr;
  assign unused_wdata = bus_wdata;
  assign sel     = reg_sel_e'(bus_addr[SEL_BIT]);
  assign load_wr = bus_wr && (sel == SEL_LOAD);
  assign clr_wr  = bus_wr && (sel == SEL_STAT) && bus_wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en     <= 1'b0;
      per_mode   <= 1'b0;
      reload_val <= '0;
    end else if (load_wr) begin
      run_en     <= bus_wdata[EN_BIT];
      per_mode   <= bus_wdata[PER_BIT];
      reload_val <= bus_wdata[CNT_W-1:0];
    end else if (expire && !per_mode) begin
      run_en     <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             run_en,
  input  logic             per_mode,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic at_zero;
  logic step;

  assign at_zero = (count == '0);
  assign step    = run_en && tick_en && !load_wr;
  assign expire  = step && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load_wr) begin
      count <= load_val;
    end else if (step) begin
      if (!at_zero)     count <= count - 1'b1;
      else if (per_mode) count <= reload_val;
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr_wr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)         irq <= 1'b0;
    else if (expire) irq <= 1'b1;
    else if (clr_wr) irq <= 1'b0;
  end
endmodule

// File: rtl/tick_timer_chan.sv
module tick_timer_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 29,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              load_wr;
  logic              clr_wr;
  logic              run_en;
  logic              per_mode;
  logic [CNT_W-1:0]  reload_val;
  logic [CNT_W-1:0]  count;
  logic              expire;
  logic [DATA_W-1:0] load_view;
  logic [DATA_W-1:0] stat_view;

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .expire(expire), .load_wr(load_wr),
    .clr_wr(clr_wr), .run_en(run_en), .per_mode(per_mode),
    .reload_val(reload_val)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .run_en(run_en),
    .per_mode(per_mode), .load_wr(load_wr),
    .load_val(bus_wdata[CNT_W-1:0]), .reload_val(reload_val),
    .count(count), .expire(expire)
  );

  tmr_irq u_irq (
    .clk(clk), .rst(rst), .expire(expire), .clr_wr(clr_wr), .irq(irq)
  );

  always_comb begin
    load_view              = '0;
    load_view[CNT_W-1:0]   = reload_val;
    load_view[EN_BIT]      = run_en;
    load_view[PER_BIT]     = per_mode;
    stat_view              = '0;
    stat_view[CNT_W-1:0]   = count;
    stat_view[IRQ_BIT]     = irq;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= bus_addr[SEL_BIT] ? stat_view : load_view;
  end
endmodule

// File: rtl/tmr_chan_checker.sv
module tmr_chan_checker #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             load_wr,
  input logic             clr_wr,
  input logic             expire,
  input logic             irq,
  input logic             run_en,
  input logic             per_mode,
  input logic [CNT_W-1:0] reload_val,
  input logic [CNT_W-1:0] count
);
  a_r4_expiry_sets_irq: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq);

  a_r8_irq_holds: assert property (@(posedge clk) disable iff (rst)
    irq && !clr_wr |=> irq);

  a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
    clr_wr && !expire |=> !irq);

  a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
    expire && !per_mode |=> !run_en && (count == '0));

  a_r6_reload: assert property (@(posedge clk) disable iff (rst)
    expire && per_mode |=> count == $past(reload_val));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !load_wr && !(tick_en && run_en) |=> $stable(count));

  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    run_en && tick_en && !load_wr && (count != '0) |=> count == CNT_W'($past(count) - 1'b1));

  a_r7_stays_off: assert property (@(posedge clk) disable iff (rst)
    !run_en && !load_wr |=> !run_en);
endmodule

bind tick_timer_chan tmr_chan_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .load_wr(load_wr),
  .clr_wr(clr_wr), .expire(expire), .irq(irq), .run_en(run_en),
  .per_mode(per_mode), .reload_val(reload_val), .count(count)
);

// File: tb/test_tick_timer_chan.sv
`timescale 1ns/1ps
module test_tick_timer_chan;
  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] PER = 32'h4000_0000;
  localparam logic [31:0] CLR = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #4 clk = ~clk;

  tick_timer_chan i_tick_timer_chan (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_en, m_per, m_irq;
  int unsigned m_val, m_cnt;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    bit ld, clr, ex;
    if (rst) begin
      m_en = 0; m_per = 0; m_irq = 0; m_val = 0; m_cnt = 0; m_rdata = 0;
    end else begin
      ld  = bus_wr && !bus_addr[2];
      clr = bus_wr && bus_addr[2] && bus_wdata[30];
      if (bus_rd) begin
        if (bus_addr[2]) m_rdata = (m_irq ? 32'h4000_0000 : 32'h0) | m_cnt;
        else             m_rdata = {m_en, m_per, 1'b0, m_val[28:0]};
      end
      ex = m_en && tick_en && !ld && (m_cnt == 0);
      if (ex) m_irq = 1;
      else if (clr) m_irq = 0;
      if (ld) begin
        m_en  = bus_wdata[31];
        m_per = bus_wdata[30];
        m_val = bus_wdata & 32'h1FFF_FFFF;
        m_cnt = m_val;
      end else if (m_en && tick_en) begin
        if (m_cnt == 0) begin
          if (m_per) m_cnt = m_val;
          else m_en = 0;
        end else begin
          m_cnt--;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq === m_irq, "R4 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      chk(bus_rdata === m_rdata, "R10 rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic ticks(input int n);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk(irq === 1'b0, "R1 irq in reset", {31'd0, irq}, 32'd0);
    chk(bus_rdata === 32'd0, "R1 rdata in reset", bus_rdata, 32'd0);
    rst = 0;
    rd(3'd0, v); chk(v === 32'd0, "R1 load word after reset", v, 32'd0);
    rd(3'd4, v); chk(v === 32'd0, "R1 status after reset", v, 32'd0);

    // oneshot N=3: fires on the 4th tick
    wr(3'd0, EN | 32'd3);
    ticks(3); chk(irq === 1'b0, "R4 no irq after N ticks", {31'd0, irq}, 32'd0);
    ticks(1); chk(irq === 1'b1, "R4 irq on tick N+1", {31'd0, irq}, 32'd1);
    rd(3'd0, v); chk(v === 32'd3, "R5 enable cleared after oneshot", v, 32'd3);
    ticks(5);
    rd(3'd4, v); chk(v === 32'h4000_0000, "R5 stopped at zero", v, 32'h4000_0000);

    // clear behaviour
    wr(3'd4, 32'h0000_0001); chk(irq === 1'b1, "R8 write without clear bit", {31'd0, irq}, 32'd1);
    wr(3'd4, CLR); chk(irq === 1'b0, "R8 clear bit drops irq", {31'd0, irq}, 32'd0);

    // load 0 fires on first tick
    wr(3'd0, EN);
    ticks(1); chk(irq === 1'b1, "R4 load 0 fires after one tick", {31'd0, irq}, 32'd1);
    wr(3'd4, CLR);

    // counting only on ticks
    wr(3'd0, EN | 32'd10);
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk(v === 32'd10, "R3 no ticks no change", v, 32'd10);
    ticks(4);
    rd(3'd4, v); chk(v === 32'd6, "R3 four ticks", v, 32'd6);

    // restart mid count
    wr(3'd0, EN | 32'd2);
    rd(3'd4, v); chk(v === 32'd2, "R2 restart from new value", v, 32'd2);
    ticks(2); chk(irq === 1'b0, "R2 no early expiry", {31'd0, irq}, 32'd0);
    ticks(1); chk(irq === 1'b1, "R2 expiry after restart", {31'd0, irq}, 32'd1);
    wr(3'd4, CLR);

    // load overrides tick in same cycle
    tick_en = 1;
    wr(3'd0, EN | 32'd5);
    tick_en = 0;
    rd(3'd4, v); chk(v === 32'd5, "R2 load wins over tick", v, 32'd5);

    // periodic N=1
    wr(3'd0, EN | PER | 32'd1);
    ticks(2); chk(irq === 1'b1, "R6 first periodic expiry", {31'd0, irq}, 32'd1);
    wr(3'd4, CLR);
    ticks(1); chk(irq === 1'b0, "R6 mid period", {31'd0, irq}, 32'd0);
    ticks(1); chk(irq === 1'b1, "R6 second periodic expiry", {31'd0, irq}, 32'd1);
    rd(3'd4, v); chk(v === 32'h4000_0001, "R6 reloaded count", v, 32'h4000_0001);
    rd(3'd0, v); chk(v === (EN | PER | 32'd1), "R6 stays enabled", v, EN | PER | 32'd1);

    // clear colliding with expiry
    wr(3'd4, CLR);
    wr(3'd0, EN | PER);
    tick_en = 1; bus_wr = 1; bus_addr = 3'd4; bus_wdata = CLR;
    @(negedge clk);
    tick_en = 0; bus_wr = 0; bus_wdata = 0;
    chk(irq === 1'b1, "R9 expiry beats clear", {31'd0, irq}, 32'd1);
    wr(3'd4, CLR); chk(irq === 1'b0, "R8 later clear", {31'd0, irq}, 32'd0);

    // stop
    wr(3'd0, 32'd0);
    ticks(50); chk(irq === 1'b0, "R7 stopped channel silent", {31'd0, irq}, 32'd0);
    rd(3'd4, v); chk(v === 32'd0, "R7 count cleared", v, 32'd0);

    // readback fields and ignored low address bits
    wr(3'd0, EN | PER | 32'h1FFF_FFFF);
    rd(3'd0, v); chk(v === 32'hDFFF_FFFF, "R10 load word readback", v, 32'hDFFF_FFFF);
    rd(3'd5, v); chk(v === 32'h1FFF_FFFF, "R10 status via offset 5", v, 32'h1FFF_FFFF);
    repeat (3) @(negedge clk);
    chk(bus_rdata === 32'h1FFF_FFFF, "R10 rdata holds", bus_rdata, 32'h1FFF_FFFF);
    wr(3'd0, 32'd0);

    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog R1-all actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule